// File: doc/BRIEF.md
# Host-to-DMA Word FIFO Bridge

This block lets a 16-bit host processor stream words into a small FIFO, which a single DMA channel then empties into a word-addressed memory. The host sees three registers behind one select field: a control register (enable, DMA-mode and RV bits plus a read-only FULL flag), a transfer-length register and a FIFO data port. The DMA side holds the channel registers: destination address, transfer count, channel control and a master-enable word. It drives 16-bit memory write requests through a valid/ready handshake.

A drain is triggered only by a host push that leaves the FIFO holding a nonzero multiple of four words, and only while the channel is in mode 01 and master enable is set. A drain writes the stored words in FIFO order to consecutive halfword addresses. It stops early when the DMA count runs out, and afterwards the FIFO is empty. The host length and the DMA count are kept apart. When the host length is spent, the host enable bit clears. When the DMA count is spent, the channel's transfer-end bit is set.

Top module: `host_dma_fifo_bridge`

## Requirements
- R1: A host write to the length register (select 1) stores the written value with bits [1:0] forced to zero.
- R2: A host write to the data port (select 2) is discarded while control bit 0 (enable) is clear.
- R3: An accepted data-port write is pushed while the FIFO holds fewer than DEPTH words. Control bit 7 (FULL) reads 1 while the FIFO holds DEPTH words.
- R4: A drain starts only after a push that leaves a nonzero multiple of four words, with channel control bits [1:0] equal to 01 and master-enable bit 0 set.
- R5: During a drain, the stored words go out in push order, one per accepted handshake. Each is written to the current destination, which then advances by 2. Address and data stay stable while mem_wready_i is low.
- R6: Each word written decrements both the DMA count and the host length by one. The drain ends when the stored words run out or the DMA count reaches zero, and any words left over are discarded.
- R7: After a drain, the FIFO is empty and FULL reads 0. Enable clears if the host length is zero and is kept otherwise.
- R8: If the DMA count is zero at the end of a drain, channel control bit 1 (transfer end) is set.
- R9: A control-register write (select 0) updates only bits 0 (enable), 1 (DMA) and 2 (RV). FULL ignores the written bit 7.
- R10: While a drain runs, host_rdy_o is low and both host writes and channel-register writes are ignored.
- R11: After reset, every register reads zero, host_rdy_o is high and mem_wvalid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_sel_i | input | 2 | Host register select: 0 control, 1 length, 2 data port |
| host_wdata_i | input | 16 | Host write data |
| host_rdy_o | output | 1 | Host writes accepted (low during a drain) |
| host_raddr_i | input | 2 | Host read select |
| host_rdata_o | output | 16 | Host read data |
| cfg_wr_i | input | 1 | Channel register write strobe |
| cfg_sel_i | input | 2 | Channel select: 0 destination, 1 count, 2 control, 3 master enable |
| cfg_wdata_i | input | 32 | Channel write data |
| cfg_raddr_i | input | 2 | Channel read select |
| cfg_rdata_o | output | 32 | Channel read data |
| mem_wvalid_o | output | 1 | Memory write request valid |
| mem_wready_i | input | 1 | Memory write accepted |
| mem_waddr_o | output | 32 | Memory write address |
| mem_wdata_o | output | 16 | Memory write data |

## Verification
The bench builds the block with its defaults: DEPTH 8, a burst size of 4, and 32-bit address and configuration words. With these values, two bursts fit in one FIFO fill. Eight pushes to a disarmed channel reach the FULL corner, and a count smaller than the burst truncates a drain part way through. A toggling and a held-low write-ready cover the handshake stall and the lockout of both register ports while a drain is in flight.

// File: rtl/hdb_pkg.sv
package hdb_pkg;
  typedef enum logic [1:0] {
    HR_CTRL = 2'd0,
    HR_LEN  = 2'd1,
    HR_DATA = 2'd2,
    HR_NONE = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    CF_DST    = 2'd0,
    CF_CNT    = 2'd1,
    CF_CHCTL  = 2'd2,
    CF_MASTER = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_DMA_BIT  = 1;
  localparam int unsigned CTRL_RV_BIT   = 2;
  localparam int unsigned CTRL_FULL_BIT = 7;

  localparam logic [1:0] CH_MODE_ARMED = 2'b01;
  localparam int unsigned CH_END_BIT   = 1;
endpackage

// File: rtl/hdb_host_regs.sv
module hdb_host_regs
  import hdb_pkg::*;
#(
  parameter int unsigned HDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [1:0]         sel_i,
  input  logic [HDATA_W-1:0] wdata_i,
  input  logic               len_dec_i,
  input  logic               drain_done_i,
  input  logic               full_i,
  input  logic [1:0]         raddr_i,
  output logic               en_o,
  output logic [HDATA_W-1:0] rdata_o
);
  logic               en_q, dma_q, rv_q;
  logic [HDATA_W-1:0] len_q;
  logic               wr_ctrl, wr_len;

  assign wr_ctrl = wr_i && (host_sel_e'(sel_i) == HR_CTRL);
  assign wr_len  = wr_i && (host_sel_e'(sel_i) == HR_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dma_q <= 1'b0;
      rv_q  <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= wdata_i[CTRL_EN_BIT];
      dma_q <= wdata_i[CTRL_DMA_BIT];
      rv_q  <= wdata_i[CTRL_RV_BIT];
    end else if (drain_done_i && len_q == '0) begin
      en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        len_q <= '0;
    else if (wr_len)    len_q <= {wdata_i[HDATA_W-1:2], 2'b00};
    else if (len_dec_i) len_q <= len_q - HDATA_W'(1);
  end

  always_comb begin
    rdata_o = '0;
    unique case (host_sel_e'(raddr_i))
      HR_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_DMA_BIT]  = dma_q;
        rdata_o[CTRL_RV_BIT]   = rv_q;
        rdata_o[CTRL_FULL_BIT] = full_i;
      end
      HR_LEN:  rdata_o = len_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  p_len_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_len |=> len_q[1:0] == 2'b00);

  p_en_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_done_i && len_q == '0) |=> !en_q);
endmodule

// File: rtl/hdb_fifo.sv
module hdb_fifo #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned BURST   = 4,
  parameter int unsigned HDATA_W = 16,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [HDATA_W-1:0] wdata_i,
  input  logic               busy_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [HDATA_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               full_o,
  output logic               burst_hit_o
);
  logic [LVL_W-1:0]   level_q, level_nxt;
  logic [HDATA_W-1:0] mem_q [DEPTH];
  logic               push_ok;

  assign full_o      = (level_q == LVL_W'(DEPTH));
  assign push_ok     = push_i && !full_o;
  assign level_nxt   = level_q + LVL_W'(1);
  assign burst_hit_o = push_ok && ((level_nxt % LVL_W'(BURST)) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      level_q <= '0;
    else if (clr_i)   level_q <= '0;
    else if (push_ok) level_q <= level_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_ok && level_q == LVL_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign level_o   = level_q;

  p_level_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));

  p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i) |=> $stable(level_q));
endmodule

// File: rtl/hdb_dma_chan.sv
module hdb_dma_chan
  import hdb_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned HDATA_W = 16,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CTL_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [1:0]         cfg_raddr_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic               burst_hit_i,
  input  logic [LVL_W-1:0]   level_i,
  input  logic [HDATA_W-1:0] rd_data_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               len_dec_o,
  output logic               mem_wvalid_o,
  input  logic               mem_wready_i,
  output logic [ADDR_W-1:0]  mem_waddr_o,
  output logic [HDATA_W-1:0] mem_wdata_o
);
  logic [ADDR_W-1:0] dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTL_W-1:0]  chctl_q;
  logic              master_q;
  logic              busy_q;
  logic [LVL_W-1:0]  idx_q;
  logic              armed, start, stop, fire, cfg_ok;

  assign armed  = (chctl_q[1:0] == CH_MODE_ARMED) && master_q;
  assign start  = burst_hit_i && armed && !busy_q;
  assign stop   = (cnt_q == '0) || (idx_q == level_i);
  assign done_o = busy_q && stop;
  assign mem_wvalid_o = busy_q && !stop;
  assign fire   = mem_wvalid_o && mem_wready_i;
  assign cfg_ok = cfg_wr_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q    <= '0;
      cnt_q    <= '0;
      chctl_q  <= '0;
      master_q <= 1'b0;
    end else begin
      if (cfg_ok) begin
        unique case (cfg_sel_e'(cfg_sel_i))
          CF_DST:    dst_q    <= cfg_wdata_i[ADDR_W-1:0];
          CF_CNT:    cnt_q    <= cfg_wdata_i[CNT_W-1:0];
          CF_CHCTL:  chctl_q  <= cfg_wdata_i[CTL_W-1:0];
          CF_MASTER: master_q <= cfg_wdata_i[0];
          default: ;
        endcase
      end
      if (fire) begin
        dst_q <= dst_q + ADDR_W'(2);
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (done_o && cnt_q == '0) chctl_q[CH_END_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      idx_q  <= idx_q + LVL_W'(1);
    end
  end

  always_comb begin
    unique case (cfg_sel_e'(cfg_raddr_i))
      CF_DST:    cfg_rdata_o = CFG_W'(dst_q);
      CF_CNT:    cfg_rdata_o = CFG_W'(cnt_q);
      CF_CHCTL:  cfg_rdata_o = CFG_W'(chctl_q);
      default:   cfg_rdata_o = CFG_W'(master_q);
    endcase
  end

  assign rd_idx_o    = idx_q[IDX_W-1:0];
  assign busy_o      = busy_q;
  assign len_dec_o   = fire;
  assign mem_waddr_o = dst_q;
  assign mem_wdata_o = rd_data_i;

  p_wr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wvalid_o && !mem_wready_i) |=>
      (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)));

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (!mem_wvalid_o || mem_waddr_o == $past(mem_waddr_o) + ADDR_W'(2)));

  p_start_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(burst_hit_i));

  p_cnt_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |-> !mem_wvalid_o);

  p_end_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cnt_q == '0) |=> chctl_q[CH_END_BIT]);
endmodule

// File: rtl/host_dma_fifo_bridge.sv
module host_dma_fifo_bridge
  import hdb_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned BURST   = 4,
  parameter int unsigned HDATA_W = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned CFG_W   = 32,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic [1:0]         host_sel_i,
  input  logic [HDATA_W-1:0] host_wdata_i,
  output logic               host_rdy_o,
  input  logic [1:0]         host_raddr_i,
  output logic [HDATA_W-1:0] host_rdata_o,
  input  logic               cfg_wr_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [1:0]         cfg_raddr_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  output logic               mem_wvalid_o,
  input  logic               mem_wready_i,
  output logic [ADDR_W-1:0]  mem_waddr_o,
  output logic [HDATA_W-1:0] mem_wdata_o
);
  logic               busy, done, len_dec, en, full, burst_hit, host_wr_ok, push;
  logic [LVL_W-1:0]   level;
  logic [IDX_W-1:0]   rd_idx;
  logic [HDATA_W-1:0] rd_data;

  assign host_rdy_o = !busy;
  assign host_wr_ok = host_wr_i && !busy;
  assign push       = host_wr_ok && en && (host_sel_e'(host_sel_i) == HR_DATA);

  hdb_host_regs #(.HDATA_W(HDATA_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (host_wr_ok),
    .sel_i       (host_sel_i),
    .wdata_i     (host_wdata_i),
    .len_dec_i   (len_dec),
    .drain_done_i(done),
    .full_i      (full),
    .raddr_i     (host_raddr_i),
    .en_o        (en),
    .rdata_o     (host_rdata_o)
  );

  hdb_fifo #(.DEPTH(DEPTH), .BURST(BURST), .HDATA_W(HDATA_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .wdata_i    (host_wdata_i),
    .busy_i     (busy),
    .clr_i      (done),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data),
    .level_o    (level),
    .full_o     (full),
    .burst_hit_o(burst_hit)
  );

  hdb_dma_chan #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CFG_W(CFG_W), .HDATA_W(HDATA_W)
  ) u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_raddr_i (cfg_raddr_i),
    .cfg_rdata_o (cfg_rdata_o),
    .burst_hit_i (burst_hit),
    .level_i     (level),
    .rd_data_i   (rd_data),
    .rd_idx_o    (rd_idx),
    .busy_o      (busy),
    .done_o      (done),
    .len_dec_o   (len_dec),
    .mem_wvalid_o(mem_wvalid_o),
    .mem_wready_i(mem_wready_i),
    .mem_waddr_o (mem_waddr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  p_no_push_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !push);

  p_full_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !full);
endmodule

// File: tb/host_dma_fifo_bridge_bench.sv
module host_dma_fifo_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [15:0] host_wdata = '0;
  logic        host_rdy;
  logic [1:0]  host_raddr = '0;
  logic [15:0] host_rdata;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        mem_wvalid;
  logic        mem_wready = 1'b1;
  logic [31:0] mem_waddr;
  logic [15:0] mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit stall_mode = 1'b0;
  bit hold_low   = 1'b0;

  logic [31:0] log_addr [64];
  logic [15:0] log_data [64];
  int          log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_dma_fifo_bridge u_host_dma_fifo_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_sel_i(host_sel), .host_wdata_i(host_wdata),
    .host_rdy_o(host_rdy), .host_raddr_i(host_raddr), .host_rdata_o(host_rdata),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cfg_raddr_i(cfg_raddr), .cfg_rdata_o(cfg_rdata),
    .mem_wvalid_o(mem_wvalid), .mem_wready_i(mem_wready),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_wvalid && mem_wready && log_n < 64) begin
      log_addr[log_n] <= mem_waddr;
      log_data[log_n] <= mem_wdata;
      log_n <= log_n + 1;
    end
    if (cyc == WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog (all R) act=%0d cycles exp=<%0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (hold_low)        mem_wready <= 1'b0;
    else if (stall_mode) mem_wready <= ~mem_wready;
    else                 mem_wready <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [15:0] d);
    host_raddr = sel; #1; d = host_rdata;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
    cfg_raddr = sel; #1; d = cfg_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!host_rdy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    log_n = 0;
    @(negedge clk);
  endtask

  task automatic push4(input logic [15:0] base);
    for (int i = 0; i < 4; i++) host_write(2'd2, base + 16'(i));
  endtask

  task automatic t_reset_state();
    logic [15:0] h; logic [31:0] c;
    host_read(2'd0, h); check("R11 ctrl", 32'(h), 32'h0);
    host_read(2'd1, h); check("R11 len", 32'(h), 32'h0);
    for (int s = 0; s < 4; s++) begin
      cfg_read(2'(s), c); check("R11 cfg", c, 32'h0);
    end
    check("R11 rdy", 32'(host_rdy), 32'h1);
    check("R11 wvalid", 32'(mem_wvalid), 32'h0);
  endtask

  task automatic t_len_align();
    logic [15:0] h;
    host_write(2'd1, 16'h0013);
    host_read(2'd1, h); check("R1 len 0x13", 32'(h), 32'h0010);
    host_write(2'd1, 16'hFFFF);
    host_read(2'd1, h); check("R1 len 0xffff", 32'(h), 32'hFFFC);
  endtask

  task automatic t_first_bursts();
    logic [15:0] h; logic [31:0] c; int b;
    cfg_write(2'd0, 32'h1000);
    cfg_write(2'd1, 32'd16);
    cfg_write(2'd2, 32'h1);
    cfg_write(2'd3, 32'h1);
    host_write(2'd0, 16'h0000);
    push4(16'h9900);
    repeat (4) @(negedge clk);
    check("R2 no write while disabled", 32'(log_n), 32'd0);
    host_write(2'd0, 16'h0001);
    host_write(2'd1, 16'd8);
    b = log_n;
    push4(16'hA000);
    wait_idle();
    check("R2/R5 burst size", 32'(log_n - b), 32'd4);
    for (int i = 0; i < 4; i++) begin
      check("R5 addr", log_addr[b+i], 32'h1000 + 32'(2*i));
      check("R5 data", 32'(log_data[b+i]), 32'hA000 + 32'(i));
    end
    cfg_read(2'd1, c); check("R6 count", c, 32'd12);
    host_read(2'd1, h); check("R6 len", 32'(h), 32'd4);
    host_read(2'd0, h); check("R7 en kept", 32'(h), 32'h0001);
    b = log_n;
    push4(16'hB000);
    wait_idle();
    check("R5 second burst", 32'(log_n - b), 32'd4);
    check("R5 addr cont", log_addr[b], 32'h1008);
    check("R5 data cont", 32'(log_data[b+3]), 32'hB003);
    host_read(2'd0, h); check("R7 en cleared len0", 32'(h), 32'h0000);
    cfg_read(2'd2, c); check("R8 no end flag", c, 32'h1);
  endtask

  task automatic t_count_stop();
    logic [15:0] h; logic [31:0] c; int b;
    cfg_write(2'd1, 32'd2);
    host_write(2'd0, 16'h0001);
    host_write(2'd1, 16'd8);
    stall_mode = 1'b1;
    b = log_n;
    push4(16'hC000);
    wait_idle();
    stall_mode = 1'b0;
    check("R6 stop at count", 32'(log_n - b), 32'd2);
    check("R5 stall addr", log_addr[b+1], 32'h1012);
    check("R5 stall data", 32'(log_data[b+1]), 32'hC001);
    cfg_read(2'd2, c); check("R8 end flag", c, 32'h3);
    cfg_read(2'd0, c); check("R5 dst", c, 32'h1014);
    host_read(2'd1, h); check("R6 len partial", 32'(h), 32'd6);
    host_read(2'd0, h); check("R7 en kept/empty", 32'(h), 32'h0001);
    b = log_n;
    push4(16'hD000);
    repeat (4) @(negedge clk);
    check("R4 mode 11 no burst", 32'(log_n - b), 32'd0);
    host_read(2'd0, h); check("R3 not full at 4", 32'(h), 32'h0001);
    push4(16'hD100);
    host_read(2'd0, h); check("R3 full at depth", 32'(h), 32'h0081);
    host_write(2'd0, 16'h0006);
    host_read(2'd0, h); check("R9 full kept", 32'(h), 32'h0086);
  endtask

  task automatic t_master_gate();
    logic [15:0] h;
    do_reset();
    host_write(2'd0, 16'h0087);
    host_read(2'd0, h); check("R9 full not writable", 32'(h), 32'h0007);
    cfg_write(2'd0, 32'h2000);
    cfg_write(2'd1, 32'd8);
    cfg_write(2'd2, 32'h1);
    host_write(2'd1, 16'd8);
    push4(16'hE000);
    push4(16'hE100);
    repeat (4) @(negedge clk);
    check("R4 master off", 32'(log_n), 32'd0);
    host_read(2'd0, h); check("R3 full", 32'(h), 32'h0087);
  endtask

  task automatic t_lockout();
    logic [15:0] h; logic [31:0] c;
    do_reset();
    cfg_write(2'd0, 32'h3000);
    cfg_write(2'd1, 32'd8);
    cfg_write(2'd2, 32'h1);
    cfg_write(2'd3, 32'h1);
    host_write(2'd1, 16'd8);
    host_write(2'd0, 16'h0001);
    hold_low = 1'b1;
    @(negedge clk);
    push4(16'hF000);
    check("R10 rdy low", 32'(host_rdy), 32'h0);
    check("R5 held valid", 32'(mem_wvalid), 32'h1);
    check("R5 held addr", mem_waddr, 32'h3000);
    host_write(2'd0, 16'h0000);
    host_write(2'd1, 16'd100);
    cfg_write(2'd1, 32'd100);
    hold_low = 1'b0;
    wait_idle();
    check("R10 burst words", 32'(log_n), 32'd4);
    cfg_read(2'd1, c); check("R10 cfg ignored", c, 32'd4);
    host_read(2'd1, h); check("R10 len ignored", 32'(h), 32'd4);
    host_read(2'd0, h); check("R10 ctrl ignored", 32'(h), 32'h0001);
    check("R10 rdy back", 32'(host_rdy), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_len_align();
    t_first_bursts();
    t_count_stop();
    t_master_gate();
    t_lockout();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule